// File: doc/BRIEF.md
# Channel-List ADC Sequencer

This block is the register-side controller of a sixteen-input multiplexed analog-to-digital converter. Software loads a short list of conversion descriptors (input number, gain code, unipolar and differential flags) through a data port. Then, in software-trigger mode, every bus read of the first control register starts one conversion. The controller takes the next descriptor from the list and drives it onto the multiplexer, gain and polarity outputs. A modelled converter with a fixed latency finishes the conversion, and its 12-bit sample goes into a result queue. Software drains that queue through the same data port address.

The descriptor list is not consumed. After its last entry, the next conversion starts again at the first one. A second control register enables the two queues, and clearing an enable bit empties its queue. A status register reports the queue levels and the busy state. It also holds a latched half-full interrupt flag and a sticky overflow bit, and any write to the status register clears both. Pacing by scan timer or external edge is not modelled: those mode codes are stored but never start a conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, control registers read 0, status reads 16'h0004 (result queue empty), `irq` is 0 and the mux outputs are 0.
- R2: Word addresses are 0 control-1, 1 control-2, 2 status, 3 data port. Control-1 and control-2 read back the last value written. Control-1 bits [1:0] are the mode (0 off, 1 software trigger, 2 scan, 3 external), bit 8 enables the half-full interrupt and bit 15 is the global interrupt enable.
- R3: A read of control-1 in mode 1, while idle and with a non-empty list, starts a conversion. Status bit 0 is then 1 for exactly CONV_LAT cycles. A read of control-1 in any other mode, while busy, or with an empty list starts nothing.
- R4: A descriptor has the input in bits [3:0], the gain in [5:4], unipolar in bit 6 and differential in bit 7. At a conversion start these fields appear on `mux_chan`, `mux_gain`, `mux_unipolar` and `mux_diff` and hold until the next start.
- R5: At the end of a conversion `adc_sample` is pushed into the result queue. A read of the data port returns the oldest sample in bits [11:0] with zeros above and removes it. A read of an empty queue returns 0.
- R6: The result queue holds 16 samples. A conversion that completes while it is full, with no pop in that cycle, drops its sample and sets sticky status bit 5.
- R7: The list is used circularly. After the last written entry the next conversion uses the first entry again.
- R8: Control-2 bit 9 enables the list and bit 10 enables the result queue. While a bit is 0 the matching queue is empty, list writes are discarded and finished samples are discarded.
- R9: Status bit 1 reports list full (16 entries), bit 2 result queue empty, bit 3 half full (8 or more samples) and bit 4 full. Writes to a full list are discarded.
- R10: Status bit 8 latches one cycle after the half-full condition rises, only while control-1 bit 8 is set. `irq` is status bit 8 AND control-1 bit 15.
- R11: Any write to the status register clears bits 8 and 5. A new half-full edge in the same cycle takes priority over the clear.
- R12: A list write with the differential bit set and an input number above 7 is discarded.
- R13: When a sample is pushed in the same cycle as a data-port read, both take effect. On a full queue the sample is stored and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| adc_sample | input | 12 | Converter output, taken at the end of a conversion |
| mux_chan | output | 4 | Selected analog input |
| mux_gain | output | 2 | Gain code of the current conversion |
| mux_unipolar | output | 1 | Unipolar range selected |
| mux_diff | output | 1 | Differential input selected |
| irq | output | 1 | Interrupt request |

## Verification
The result queue can be written by a finishing conversion and read through the data port in the same clock. The bench fills the queue to 16 samples, starts one more conversion and counts status reads so that a data-port read lands on the exact edge where the sample is pushed. It then expects the full flag to stay set and no overflow to be flagged, and it checks that the last sample drained is the new one. The bench also makes a status clear fall in the same cycle as a rising half-full edge, and it expects the flag to remain set.

// File: rtl/adcq_pkg.sv
// Shared types and register constants for the channel-list ADC sequencer.
// Assumes a word-addressed register bus with four registers.
package adcq_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL1 = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL2 = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd3;

    // control-1 field positions
    localparam int C1_HF_IE  = 8;
    localparam int C1_GIE    = 15;
    // control-2 field positions
    localparam int C2_LIST_EN = 9;
    localparam int C2_RES_EN  = 10;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_SCAN = 2'd2,
        MODE_EXT  = 2'd3
    } adc_mode_e;

    typedef struct packed {
        logic       diff;
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] chan;
    } chan_entry_t;
endpackage

// File: rtl/adcq_fifo.sv
// Result queue: synchronous FIFO with flush, simultaneous push/pop and a drop
// indication when a push meets a full queue without a pop in the same cycle.
// Assumes pop_i is only honoured when the queue holds data.
module adcq_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         half_o,
    output logic         drop_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_pop, do_push;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty_o = (count == '0);
    assign full_o  = (count == CW'(DEPTH));
    assign half_o  = (count >= CW'(DEPTH / 2));
    assign data_o  = mem[rptr];
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full_o || do_pop);
    assign drop_o  = push_i && full_o && !do_pop && !flush_i;

    // storage write
    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem[wptr] <= data_i;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !flush_i) |=> full_o);
    a_r5_empty_pop_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);
    a_r13_both_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o && !flush_i) |=> $stable(count));
endmodule

// File: rtl/adcq_chanlist.sv
// Descriptor list: entries are appended at the tail and read circularly by an
// index that wraps to the first entry after the last one written.
// Assumes adv_i is only asserted while the list is not empty.
module adcq_chanlist
    import adcq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_i,
    input  logic        wr_i,
    input  chan_entry_t entry_i,
    input  logic        adv_i,
    output chan_entry_t entry_o,
    output logic        empty_o,
    output logic        full_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    chan_entry_t   mem [DEPTH];
    logic [IW-1:0] idx;
    logic [CW-1:0] count;
    logic          last;

    assign empty_o = (count == '0);
    assign full_o  = (count == CW'(DEPTH));
    assign entry_o = mem[idx];
    assign last    = ((CW'(idx) + CW'(1)) == count);

    // descriptor storage
    always_ff @(posedge clk) begin
        if (wr_i && !full_o && !flush_i) mem[count[IW-1:0]] <= entry_i;
    end

    // occupancy and circular read index
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            count <= '0;
            idx   <= '0;
        end else begin
            if (wr_i && !full_o) count <= count + CW'(1);
            if (adv_i) idx <= last ? '0 : idx + IW'(1);
        end
    end

    a_r7_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && last && !flush_i) |=> (idx == '0));
    a_r9_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !flush_i) |=> full_o);
endmodule

// File: rtl/adcq_converter.sv
// Fixed-latency converter model: a start latches the descriptor and runs a
// down-counter; done_o marks the last busy cycle, when the sample is taken.
// Assumes LAT >= 1; starts while busy are ignored.
module adcq_converter
    import adcq_pkg::*;
#(
    parameter int LAT = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  chan_entry_t entry_i,
    output logic        busy_o,
    output logic        done_o,
    output chan_entry_t entry_o
);
    localparam int CNTW = $clog2(LAT + 1);

    logic [CNTW-1:0] cnt;
    chan_entry_t     ent_q;
    logic            busy_q;

    assign busy_o  = busy_q;
    assign done_o  = busy_q && (cnt == '0);
    assign entry_o = ent_q;

    // busy window and descriptor latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt    <= '0;
            ent_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt    <= CNTW'(LAT - 1);
            ent_q  <= entry_i;
        end else if (busy_q) begin
            if (cnt == '0) busy_q <= 1'b0;
            else           cnt    <= cnt - CNTW'(1);
        end
    end

    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> busy_q);
    a_r4_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_o) |=> $stable(ent_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the channel-list ADC sequencer: register decode, software trigger,
// status assembly and the half-full interrupt latch.
// Assumes single-cycle bus strobes; bus_rdata is combinational during bus_rd.
module adc_seq_ctrl
    import adcq_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int LIST_DEPTH = 16,
    parameter int RES_DEPTH  = 16,
    parameter int CONV_LAT   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic [3:0]          mux_chan,
    output logic [1:0]          mux_gain,
    output logic                mux_unipolar,
    output logic                mux_diff,
    output logic                irq
);
    localparam int PAD_W = 16 - SAMPLE_W;

    logic [15:0]         ctrl1, ctrl2;
    logic                hf_flag, hf_q, ovf_q;
    logic                rd_ctrl1, wr_stat, trig, hf_rise;
    logic                list_wr, list_empty, list_full;
    logic                res_pop, res_empty, res_full, res_half, res_drop;
    logic                busy, done;
    logic [SAMPLE_W-1:0] res_head;
    chan_entry_t         wr_entry, list_head, cur_entry;
    adc_mode_e           mode;

    assign mode     = adc_mode_e'(ctrl1[1:0]);
    assign wr_entry = chan_entry_t'(bus_wdata[7:0]);
    assign rd_ctrl1 = bus_rd && (bus_addr == ADDR_CTRL1);
    assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
    assign trig     = rd_ctrl1 && (mode == MODE_SOFT) && !busy && !list_empty;
    assign list_wr  = bus_wr && (bus_addr == ADDR_DATA) && ctrl2[C2_LIST_EN]
                      && !(wr_entry.diff && wr_entry.chan[3]);
    assign res_pop  = bus_rd && (bus_addr == ADDR_DATA);
    assign hf_rise  = res_half && !hf_q && ctrl1[C1_HF_IE];

    adcq_chanlist #(.DEPTH(LIST_DEPTH)) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (!ctrl2[C2_LIST_EN]),
        .wr_i    (list_wr),
        .entry_i (wr_entry),
        .adv_i   (trig),
        .entry_o (list_head),
        .empty_o (list_empty),
        .full_o  (list_full)
    );

    adcq_converter #(.LAT(CONV_LAT)) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (trig),
        .entry_i (list_head),
        .busy_o  (busy),
        .done_o  (done),
        .entry_o (cur_entry)
    );

    adcq_fifo #(.W(SAMPLE_W), .DEPTH(RES_DEPTH)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (!ctrl2[C2_RES_EN]),
        .push_i  (done && ctrl2[C2_RES_EN]),
        .data_i  (adc_sample),
        .pop_i   (res_pop),
        .data_o  (res_head),
        .empty_o (res_empty),
        .full_o  (res_full),
        .half_o  (res_half),
        .drop_o  (res_drop)
    );

    assign mux_chan     = cur_entry.chan;
    assign mux_gain     = cur_entry.gain;
    assign mux_unipolar = cur_entry.unipolar;
    assign mux_diff     = cur_entry.diff;
    assign irq          = hf_flag && ctrl1[C1_GIE];

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl1 <= '0;
            ctrl2 <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL1) ctrl1 <= bus_wdata;
            if (bus_addr == ADDR_CTRL2) ctrl2 <= bus_wdata;
        end
    end

    // half-full edge latch and overflow sticky bit; a new event beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hf_q    <= 1'b0;
            hf_flag <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            hf_q <= res_half;
            if (hf_rise)      hf_flag <= 1'b1;
            else if (wr_stat) hf_flag <= 1'b0;
            if (res_drop)     ovf_q   <= 1'b1;
            else if (wr_stat) ovf_q   <= 1'b0;
        end
    end

    // read data selection
    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL1: bus_rdata = ctrl1;
            ADDR_CTRL2: bus_rdata = ctrl2;
            ADDR_STAT:  bus_rdata = {7'b0, hf_flag, 2'b0, ovf_q, res_full,
                                     res_half, res_empty, list_full, busy};
            default:    bus_rdata = res_empty ? 16'h0 : {{PAD_W{1'b0}}, res_head};
        endcase
    end

    a_r3_other_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl1 && mode != MODE_SOFT && !busy) |=> !busy);
    a_r10_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hf_flag) |-> $past(ctrl1[C1_HF_IE]));
    a_r11_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !hf_rise && !res_drop) |=> (!hf_flag && !ovf_q));
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hf_flag);
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int LAT = 6;
    localparam logic [1:0] A_C1 = 2'd0, A_C2 = 2'd1, A_ST = 2'd2, A_DT = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] adc_sample = '0;
    logic [3:0]  mux_chan;
    logic [1:0]  mux_gain;
    logic        mux_unipolar, mux_diff, irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] d;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.CONV_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_sample(adc_sample), .mux_chan(mux_chan), .mux_gain(mux_gain),
        .mux_unipolar(mux_unipolar), .mux_diff(mux_diff), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic conv();
        logic [15:0] t;
        rd(A_C1, t);
        repeat (LAT + 1) @(posedge clk);
        #1;
    endtask

    task automatic setup(input logic [15:0] c1);
        wr(A_C2, 16'h0000);
        wr(A_C2, 16'h0600);
        wr(A_C1, c1);
        wr(A_ST, 16'h0000);
    endtask

    task automatic t_reset();
        rd(A_ST, d); chk("R1 status", d, 16'h0004);
        rd(A_C1, d); chk("R1 ctrl1", d, 16'h0000);
        chk("R1 irq/mux", {irq, mux_diff, mux_unipolar, mux_gain, mux_chan}, 16'h0);
    endtask

    task automatic t_regs();
        wr(A_C1, 16'h8135); rd(A_C1, d); chk("R2 ctrl1 readback", d, 16'h8135);
        wr(A_C2, 16'h06DB); rd(A_C2, d); chk("R2 ctrl2 readback", d, 16'h06DB);
        // mode 1, list empty: trigger read does nothing (R3)
        wr(A_C2, 16'h0600); wr(A_C1, 16'h0001);
        rd(A_C1, d); rd(A_ST, d); chk("R3 empty list no start", d[0], 1'b0);
    endtask

    task automatic t_single();
        setup(16'h0001);
        wr(A_DT, 16'h0065);
        adc_sample = 12'hABC;
        rd(A_C1, d);
        chk("R4 mux fields", {mux_diff, mux_unipolar, mux_gain, mux_chan}, 16'h0065);
        for (int k = 1; k <= LAT + 1; k++) begin
            rd(A_ST, d);
            if (k == 1)   chk("R3 busy after start", d[0], 1'b1);
            if (k == LAT) chk("R3 busy last cycle", d[0], 1'b1);
            if (k == LAT + 1) begin
                chk("R3 idle after latency", d[0], 1'b0);
                chk("R9 not empty", d[2], 1'b0);
            end
        end
        rd(A_DT, d); chk("R5 pop sample", d, 16'h0ABC);
        rd(A_DT, d); chk("R5 empty read zero", d, 16'h0000);
        rd(A_ST, d); chk("R5 empty again", d[2], 1'b1);
    endtask

    task automatic t_modes();
        wr(A_C1, 16'h0000); rd(A_C1, d); rd(A_ST, d);
        chk("R3 mode off no start", d[0], 1'b0);
        wr(A_C1, 16'h0002); rd(A_C1, d); rd(A_ST, d);
        chk("R3 scan mode no start", d[0], 1'b0);
        wr(A_C1, 16'h0003); rd(A_C1, d); rd(A_ST, d);
        chk("R3 ext mode no start", d[0], 1'b0);
        // retrigger while busy is ignored
        wr(A_C1, 16'h0001);
        rd(A_C1, d); rd(A_C1, d);
        repeat (3 * LAT) @(posedge clk); #1;
        rd(A_DT, d); rd(A_ST, d);
        chk("R3 busy retrigger ignored", d[2], 1'b1);
    endtask

    task automatic t_wrap();
        logic [3:0] exp_ch [4] = '{4'd1, 4'd2, 4'd3, 4'd1};
        setup(16'h0001);
        wr(A_DT, 16'h0001); wr(A_DT, 16'h0092); wr(A_DT, 16'h0003);
        for (int i = 0; i < 4; i++) begin
            conv();
            chk("R7 circular order", {12'h0, mux_chan}, {12'h0, exp_ch[i]});
            if (i == 1) chk("R4 diff gain", {mux_diff, mux_unipolar, mux_gain}, 16'h0009);
        end
    endtask

    task automatic t_diff_reject();
        setup(16'h0001);
        wr(A_DT, 16'h0089);
        wr(A_DT, 16'h0084);
        conv(); chk("R12 bad diff dropped", {12'h0, mux_chan}, 16'h0004);
        conv(); chk("R12 list holds one", {12'h0, mux_chan}, 16'h0004);
    endtask

    task automatic t_flush();
        setup(16'h0001);
        wr(A_DT, 16'h0007);
        conv(); conv();
        wr(A_C2, 16'h0200); wr(A_C2, 16'h0600);
        rd(A_ST, d); chk("R8 result flush", d[2], 1'b1);
        wr(A_C2, 16'h0200);
        conv();
        wr(A_C2, 16'h0600);
        rd(A_ST, d); chk("R8 disabled queue drops", d[2], 1'b1);
        wr(A_C2, 16'h0400);
        wr(A_DT, 16'h0005);
        wr(A_C2, 16'h0600);
        rd(A_C1, d); rd(A_ST, d);
        chk("R8 list flushed, writes dropped", d[0], 1'b0);
    endtask

    task automatic t_half();
        setup(16'h8101);
        wr(A_DT, 16'h0002);
        for (int i = 0; i < 7; i++) conv();
        rd(A_ST, d); chk("R10 no flag below half", {d[8], d[3]}, 2'b00);
        chk("R10 irq low", irq, 1'b0);
        conv();
        rd(A_ST, d); chk("R10 flag on half", {d[8], d[3]}, 2'b11);
        chk("R10 irq high", irq, 1'b1);
        wr(A_ST, 16'h0000);
        rd(A_ST, d); chk("R11 flag cleared", {d[8], d[3]}, 2'b01);
        chk("R11 irq cleared", irq, 1'b0);
        // disable: no latch
        wr(A_C2, 16'h0200); wr(A_C2, 16'h0600); wr(A_C1, 16'h8001);
        for (int i = 0; i < 8; i++) conv();
        rd(A_ST, d); chk("R10 masked no flag", {d[8], d[3]}, 2'b01);
        // clear in the same cycle as the rising edge: flag survives
        wr(A_C2, 16'h0200); wr(A_C2, 16'h0600); wr(A_C1, 16'h8101);
        for (int i = 0; i < 7; i++) conv();
        rd(A_C1, d);
        repeat (LAT) @(posedge clk);
        wr(A_ST, 16'h0000);
        rd(A_ST, d); chk("R11 set beats clear", d[8], 1'b1);
    endtask

    task automatic t_overflow();
        setup(16'h0001);
        wr(A_DT, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            adc_sample = 12'(i + 16'h100);
            conv();
        end
        rd(A_ST, d); chk("R9 full flag", {d[5], d[4]}, 2'b01);
        adc_sample = 12'hFFF;
        conv();
        rd(A_ST, d); chk("R6 overflow sticky", {d[5], d[4]}, 2'b11);
        rd(A_DT, d); chk("R6 oldest kept", d, 16'h0100);
        for (int i = 1; i < 16; i++) rd(A_DT, d);
        chk("R6 last kept", d, 16'h010F);
        rd(A_ST, d); chk("R6 dropped sample absent", {d[5], d[2]}, 2'b11);
        wr(A_ST, 16'h0000);
        rd(A_ST, d); chk("R11 overflow cleared", d[5], 1'b0);
    endtask

    task automatic t_collide();
        setup(16'h0001);
        wr(A_DT, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            adc_sample = 12'(i);
            conv();
        end
        adc_sample = 12'h5A5;
        rd(A_C1, d);
        for (int k = 1; k < LAT; k++) rd(A_ST, d);
        rd(A_DT, d); chk("R13 pop on push edge", d, 16'h0000);
        rd(A_ST, d); chk("R13 full kept, no overflow", {d[5], d[4]}, 2'b01);
        for (int i = 0; i < 16; i++) rd(A_DT, d);
        chk("R13 new sample stored", d, 16'h05A5);
        // list full status
        wr(A_C2, 16'h0400); wr(A_C2, 16'h0600);
        for (int i = 0; i < 16; i++) wr(A_DT, 16'(i));
        rd(A_ST, d); chk("R9 list full", d[1], 1'b1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_single();
        t_modes();
        t_wrap();
        t_diff_reject();
        t_flush();
        t_half();
        t_overflow();
        t_collide();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule